// File: doc/BRIEF.md
# Snooping MESI Line Controller Cluster

This block keeps one cache line coherent across a small group of caches on a snooping bus with four-state invalidation. Each cache owns a per-line controller that takes read, write and evict requests from its processor and watches every bus transaction. A read miss asks the bus for a shared fill. It lands in Exclusive when no other cache answers on the wired-OR shared line, and in Shared when one does. A write to an Exclusive line goes to Modified with no bus traffic. A write to a Shared or Invalid line asks for an exclusive fill, and that fill invalidates every other copy.

The cluster wrapper ORs all the shared-line votes into one line. It turns an external grant into a one-cycle address phase, which is followed by a fixed snoop-response cycle. It also picks a single data supplier from the clean holders when cache-to-cache transfer is enabled. Arbitration is external: an arbiter drives `grant_valid` and `grant_id` from the `bus_req` vector. Data storage is not part of the block.

Top module: `mesi_snoop_cluster`

## Requirements
- R1: After reset every line state is Invalid (encoding I=0, S=1, E=2, M=3, two bits per cache in `line_state`, cache 0 in the low bits), `bus_req` and `flush` are all zero, and `pr_ready` is all ones.
- R2: A read (op 0) accepted while Invalid raises `bus_req` and issues a shared fill. After the response cycle the line is Exclusive if `shared_line` was low during that cycle, and Shared if it was high.
- R3: During the response cycle of a shared fill, every other cache that holds the line in S, E or M drives `shared_line` high. An exclusive fill never raises it.
- R4: A read that hits in S, E or M, and a write in E or M, need no bus transaction. A write in E ends in M.
- R5: A write (op 1) in S or I raises `bus_req`, issues an exclusive fill and ends in M. At most one cache is ever in M.
- R6: A snooped shared fill demotes an M or E holder to S. An M holder also asserts `flush`.
- R7: A snooped exclusive fill moves every valid holder to I. An M holder also asserts `flush`.
- R8: With cache-to-cache transfer enabled and no M holder, exactly one clean (S or E) snooper flushes, the one with the lowest index. No more than one `flush` bit is ever high.
- R9: An evict (op 2) moves the line to I. `writeback` of that cache is high in the cycle the evict is accepted only if the line was in M.
- R10: `pr_ready` is low while a cache waits for the bus and for every cache during a response cycle, and a request offered then is ignored. A grant to a cache with no pending request starts no transaction. Op 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_valid | input | NCACHE | Processor request valid, one bit per cache |
| pr_op | input | 2*NCACHE | Request op per cache: 0 read, 1 write, 2 evict, 3 none |
| pr_ready | output | NCACHE | Request may be accepted this cycle |
| bus_req | output | NCACHE | Cache waits for a bus grant |
| grant_valid | input | 1 | Arbiter grants the bus this cycle |
| grant_id | input | IDW | Index of the granted cache |
| shared_line | output | 1 | Wired-OR shared vote during the response cycle |
| flush | output | NCACHE | Cache supplies the line during the response cycle |
| writeback | output | NCACHE | Modified line is written back on evict |
| line_state | output | 2*NCACHE | Current state of each cache's line |

## Verification
The `writeback` bit of an evict is due in the cycle the request is offered, so the bench reads it mid-cycle before the accepting edge. `bus_req` and the final state of a local hit are due one edge after acceptance. For a bus fill, `shared_line` and `flush` are valid only in the response cycle, one edge after the grant edge, and the requester's and snoopers' new states appear one edge later. The bench drives on falling edges and reads each result inside the cycle where it is due, so a one-cycle slip in any stage shows up as a mismatch.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_NOP = 2'd3} pr_op_t;
  typedef enum logic {BUS_RD = 1'b0, BUS_RDX = 1'b1} bus_cmd_t;
endpackage

// File: rtl/mesi_supplier_pick.sv
module mesi_supplier_pick #(
  parameter int NCACHE = 3
) (
  input  logic [NCACHE-1:0] cand,
  input  logic              block,
  output logic [NCACHE-1:0] pick
);
  logic [NCACHE:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NCACHE; i++) begin : g_pri
    assign pick[i]    = cand[i] & ~taken[i] & ~block;
    assign taken[i+1] = taken[i] | cand[i];
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter bit C2C = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pr_valid,
  input  logic [1:0] pr_op,
  output logic       pr_ready,
  output logic       bus_req,
  output bus_cmd_t   req_cmd,
  input  logic       grant,
  input  logic       resp_valid,
  input  logic       resp_mine,
  input  bus_cmd_t   resp_cmd,
  input  logic       shared_in,
  input  logic       supply,
  output logic       vote,
  output logic       dirty_hit,
  output logic       clean_hit,
  output logic       flush,
  output logic       writeback,
  output line_st_t   state
);
  line_st_t st_q, st_d;
  logic     pend_q, pend_d;
  bus_cmd_t pcmd_q, pcmd_d;
  logic     snoop, holds, accept;

  assign snoop    = resp_valid & ~resp_mine;
  assign holds    = (st_q != ST_I);
  assign pr_ready = ~pend_q & ~resp_valid;
  assign accept   = pr_valid & pr_ready;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    pcmd_d    = pcmd_q;
    writeback = 1'b0;
    if (resp_valid && resp_mine) begin
      if (resp_cmd == BUS_RDX) st_d = ST_M;
      else                     st_d = shared_in ? ST_S : ST_E;
    end else if (snoop) begin
      if (resp_cmd == BUS_RDX)                 st_d = ST_I;
      else if (st_q == ST_M || st_q == ST_E)   st_d = ST_S;
    end else if (accept) begin
      case (pr_op_t'(pr_op))
        OP_RD: if (!holds) begin
          pend_d = 1'b1;
          pcmd_d = BUS_RD;
        end
        OP_WR: if (st_q == ST_E || st_q == ST_M) begin
          st_d = ST_M;
        end else begin
          pend_d = 1'b1;
          pcmd_d = BUS_RDX;
        end
        OP_EV: begin
          st_d      = ST_I;
          writeback = (st_q == ST_M);
        end
        default: ;
      endcase
    end
    if (grant) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_I;
      pend_q <= 1'b0;
      pcmd_q <= BUS_RD;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pcmd_q <= pcmd_d;
    end
  end

  assign vote      = snoop & (resp_cmd == BUS_RD) & holds;
  assign dirty_hit = snoop & (st_q == ST_M);
  assign clean_hit = C2C & snoop & (st_q == ST_S || st_q == ST_E);
  assign flush     = dirty_hit | supply;
  assign bus_req   = pend_q;
  assign req_cmd   = pcmd_q;
  assign state     = st_q;
endmodule

// File: rtl/mesi_snoop_cluster.sv
module mesi_snoop_cluster
  import mesi_pkg::*;
#(
  parameter int NCACHE = 3,
  parameter bit C2C    = 1'b1,
  localparam int IDW   = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCACHE-1:0]     pr_valid,
  input  logic [2*NCACHE-1:0]   pr_op,
  output logic [NCACHE-1:0]     pr_ready,
  output logic [NCACHE-1:0]     bus_req,
  input  logic                  grant_valid,
  input  logic [IDW-1:0]        grant_id,
  output logic                  shared_line,
  output logic [NCACHE-1:0]     flush,
  output logic [NCACHE-1:0]     writeback,
  output logic [2*NCACHE-1:0]   line_state
);
  bus_cmd_t            req_cmd [NCACHE];
  line_st_t            st_arr  [NCACHE];
  logic [NCACHE-1:0]   grant_vec, vote, dirty_hit, clean_hit, supply, resp_mine;
  logic                grant_fire;
  bus_cmd_t            grant_cmd;
  logic                resp_valid;
  logic [IDW-1:0]      resp_id;
  bus_cmd_t            resp_cmd;

  always_comb begin
    grant_fire = 1'b0;
    grant_cmd  = BUS_RD;
    for (int i = 0; i < NCACHE; i++) begin
      grant_vec[i] = grant_valid && (grant_id == IDW'(i)) && bus_req[i];
      if (grant_vec[i]) begin
        grant_fire = 1'b1;
        grant_cmd  = req_cmd[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_id    <= '0;
      resp_cmd   <= BUS_RD;
    end else begin
      resp_valid <= grant_fire;
      if (grant_fire) begin
        resp_id  <= grant_id;
        resp_cmd <= grant_cmd;
      end
    end
  end

  assign shared_line = |vote;

  mesi_supplier_pick #(.NCACHE(NCACHE)) u_pick (
    .cand  (clean_hit),
    .block (|dirty_hit),
    .pick  (supply)
  );

  for (genvar i = 0; i < NCACHE; i++) begin : g_line
    assign resp_mine[i] = (resp_id == IDW'(i));
    assign line_state[2*i +: 2] = st_arr[i];

    mesi_line_ctrl #(.C2C(C2C)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .pr_valid   (pr_valid[i]),
      .pr_op      (pr_op[2*i +: 2]),
      .pr_ready   (pr_ready[i]),
      .bus_req    (bus_req[i]),
      .req_cmd    (req_cmd[i]),
      .grant      (grant_vec[i]),
      .resp_valid (resp_valid),
      .resp_mine  (resp_mine[i]),
      .resp_cmd   (resp_cmd),
      .shared_in  (shared_line),
      .supply     (supply[i]),
      .vote       (vote[i]),
      .dirty_hit  (dirty_hit[i]),
      .clean_hit  (clean_hit[i]),
      .flush      (flush[i]),
      .writeback  (writeback[i]),
      .state      (st_arr[i])
    );
  end
endmodule

// File: rtl/mesi_cluster_chk.sv
module mesi_cluster_chk #(
  parameter int NCACHE = 3,
  localparam int IDW   = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCACHE-1:0]   pr_ready,
  input logic [NCACHE-1:0]   bus_req,
  input logic                grant_valid,
  input logic                shared_line,
  input logic [NCACHE-1:0]   flush,
  input logic [NCACHE-1:0]   writeback,
  input logic [2*NCACHE-1:0] line_state,
  input logic                resp_valid
);
  logic [NCACHE-1:0] m_vec;

  for (genvar i = 0; i < NCACHE; i++) begin : g_m
    assign m_vec[i] = (line_state[2*i +: 2] == 2'd3);

    assert_wb_then_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      writeback[i] |=> (line_state[2*i +: 2] == 2'd0));
  end

  assert_single_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush));

  assert_shared_in_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shared_line |-> resp_valid);

  assert_req_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req & pr_ready) == '0);

  assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_vec) <= 1);

  assert_resp_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(grant_valid && (bus_req != '0)));
endmodule

bind mesi_snoop_cluster mesi_cluster_chk #(.NCACHE(NCACHE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pr_ready    (pr_ready),
  .bus_req     (bus_req),
  .grant_valid (grant_valid),
  .shared_line (shared_line),
  .flush       (flush),
  .writeback   (writeback),
  .line_state  (line_state),
  .resp_valid  (resp_valid)
);

// File: tb/tb_mesi_snoop_cluster.sv
module tb_mesi_snoop_cluster;
  localparam int N   = 3;
  localparam int IDW = 2;
  localparam int NV  = 17;

  // vector: [15:14] cache, [13:12] op, [11:6] states c2..c0, [5] shared, [4:2] flush, [1] wb, [0] bus
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd0, 6'b00_00_10, 1'b0, 3'b000, 1'b0, 1'b1},
    {2'd0, 2'd1, 6'b00_00_11, 1'b0, 3'b000, 1'b0, 1'b0},
    {2'd1, 2'd0, 6'b00_01_01, 1'b1, 3'b001, 1'b0, 1'b1},
    {2'd2, 2'd0, 6'b01_01_01, 1'b1, 3'b001, 1'b0, 1'b1},
    {2'd1, 2'd1, 6'b00_11_00, 1'b0, 3'b001, 1'b0, 1'b1},
    {2'd1, 2'd0, 6'b00_11_00, 1'b0, 3'b000, 1'b0, 1'b0},
    {2'd1, 2'd2, 6'b00_00_00, 1'b0, 3'b000, 1'b1, 1'b0},
    {2'd2, 2'd1, 6'b11_00_00, 1'b0, 3'b000, 1'b0, 1'b1},
    {2'd0, 2'd1, 6'b00_00_11, 1'b0, 3'b100, 1'b0, 1'b1},
    {2'd1, 2'd0, 6'b00_01_01, 1'b1, 3'b001, 1'b0, 1'b1},
    {2'd0, 2'd2, 6'b00_01_00, 1'b0, 3'b000, 1'b0, 1'b0},
    {2'd2, 2'd0, 6'b01_01_00, 1'b1, 3'b010, 1'b0, 1'b1},
    {2'd1, 2'd2, 6'b01_00_00, 1'b0, 3'b000, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'b01_00_01, 1'b1, 3'b100, 1'b0, 1'b1},
    {2'd2, 2'd2, 6'b00_00_01, 1'b0, 3'b000, 1'b0, 1'b0},
    {2'd0, 2'd1, 6'b00_00_11, 1'b0, 3'b000, 1'b0, 1'b1},
    {2'd0, 2'd3, 6'b00_00_11, 1'b0, 3'b000, 1'b0, 1'b0}
  };

  logic           clk, rst_n;
  logic [N-1:0]   pr_valid;
  logic [2*N-1:0] pr_op;
  logic [N-1:0]   pr_ready, bus_req, flush, writeback;
  logic           grant_valid, shared_line;
  logic [IDW-1:0] grant_id;
  logic [2*N-1:0] line_state;
  int checks, fails;

  mesi_snoop_cluster #(.NCACHE(N), .C2C(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_op(pr_op),
    .pr_ready(pr_ready), .bus_req(bus_req), .grant_valid(grant_valid),
    .grant_id(grant_id), .shared_line(shared_line), .flush(flush),
    .writeback(writeback), .line_state(line_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(input int id, input logic [1:0] op, output logic wb);
    @(negedge clk);
    pr_valid[id]     = 1'b1;
    pr_op[2*id +: 2] = op;
    #1 wb = writeback[id];
    @(negedge clk);
    pr_valid = '0;
  endtask

  task automatic run_vec(input logic [15:0] v);
    int id;
    logic wb;
    id = int'(v[15:14]);
    offer(id, v[13:12], wb);
    chk("R9 writeback", int'(wb), int'(v[1]));
    chk("R2/R4/R5 bus_req", int'(bus_req[id]), int'(v[0]));
    if (bus_req[id]) begin
      grant_valid = 1'b1;
      grant_id    = IDW'(id);
      @(negedge clk);
      grant_valid = 1'b0;
      chk("R3 shared_line", int'(shared_line), int'(v[5]));
      chk("R6/R7/R8 flush", int'(flush), int'(v[4:2]));
      @(negedge clk);
    end
    chk("R2/R4/R5/R6/R7/R9 line_state", int'(line_state), int'(v[11:6]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic wb;
    checks = 0; fails = 0;
    rst_n = 1'b0; pr_valid = '0; pr_op = '0; grant_valid = 1'b0; grant_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line_state", int'(line_state), 0);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 flush", int'(flush), 0);
    chk("R1 pr_ready", int'(pr_ready), 7);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R10: grant to an idle cache while cache 0 holds M must start nothing
    grant_valid = 1'b1; grant_id = 2'd1;
    @(negedge clk);
    grant_valid = 1'b0;
    chk("R10 stray grant flush", int'(flush), 0);
    chk("R10 stray grant pr_ready", int'(pr_ready), 7);
    @(negedge clk);
    chk("R10 stray grant line_state", int'(line_state), 6'b00_00_11);

    // R10: request while waiting for the bus is ignored
    offer(1, 2'd0, wb);
    chk("R10 pending bus_req", int'(bus_req[1]), 1);
    chk("R10 pending pr_ready", int'(pr_ready[1]), 0);
    offer(1, 2'd1, wb);
    grant_valid = 1'b1; grant_id = 2'd1;
    @(negedge clk);
    grant_valid = 1'b0;
    chk("R10 response pr_ready", int'(pr_ready), 0);
    chk("R3 vote from M", int'(shared_line), 1);
    chk("R6 dirty flush", int'(flush), 3'b001);
    @(negedge clk);
    chk("R10 ignored write line_state", int'(line_state), 6'b00_01_01);
    chk("R10 bus_req cleared", int'(bus_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule